// File: doc/BRIEF.md
# Floating-Point Min/Max Selection Unit

This unit picks one of two IEEE-754 operands according to one of four selection operations: minimum, maximum, minimum by magnitude and maximum by magnitude. Operands are either single precision (the low 32 bits of each 64-bit input) or double precision (all 64 bits). The chosen operand is returned bit for bit. No rounding or arithmetic takes place, so the sign of a returned value is always the sign it had on input.

An issue is one cycle with `in_valid` high. It carries the 5-bit function code, the precision bit and both operands. One clock edge later the unit registers the result and pulses `out_valid`. If `fp_en` is low when an issue arrives, the unit pulses `fp_disabled_trap` instead and leaves its result untouched. Comparisons are quiet. A signaling NaN in either operand sets a sticky invalid flag, and only reset clears that flag.

NaN handling is deliberately asymmetric. When the second operand is a NaN, the result is always the first operand, whatever the first operand holds.

Top module: `fp_minmax_unit`

## Requirements
- R1: If operand B is a NaN, the result is operand A for every operation, even when A is itself a NaN. A NaN is an all-ones exponent with a nonzero mantissa.
- R2: Minimum (function code 0x18) returns A when A is quietly less than B, and returns B otherwise. This includes the case where A is a NaN and B is not, which returns B.
- R3: Maximum (function code 0x19) returns A when B is quietly less than or equal to A, and returns B otherwise.
- R4: Minimum-magnitude (0x1a) and maximum-magnitude (0x1b) compare the operands with their sign bits cleared. They follow the same rules as R2 and R3, and they return the chosen operand with its original sign.
- R5: A function code outside 0x18 to 0x1b, issued with `fp_en` high, produces no `out_valid`, no trap, and no change to the result.
- R6: `dbl`=0 selects single precision. Only bits [31:0] of each operand are used, and result bits [63:32] are zero. `dbl`=1 selects double precision over all 64 bits.
- R7: +0 and -0 compare equal. For such a pair, minimum returns B and maximum returns A.
- R8: A signaling NaN in either operand of an accepted issue sets `invalid_sticky`. A signaling NaN has a mantissa MSB of 0 and a nonzero mantissa. A quiet NaN leaves the flag unchanged. Once set, the flag stays set until reset.
- R9: An issue with `fp_en` low raises `fp_disabled_trap` for exactly one cycle, one cycle later. It gives no `out_valid`, and neither the result nor `invalid_sticky` changes.
- R10: `out_valid` pulses for exactly one cycle, one cycle after an accepted issue. A synchronous active-high reset clears `out_valid`, `fp_disabled_trap`, `invalid_sticky` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| fp_en | input | 1 | Floating-point unit enabled |
| func | input | 5 | Function code (0x18 min, 0x19 max, 0x1a min-magnitude, 0x1b max-magnitude) |
| dbl | input | 1 | Precision select: 0 single, 1 double |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Selected operand |
| invalid_sticky | output | 1 | Accumulated invalid-operation flag |
| fp_disabled_trap | output | 1 | Trap pulse for an issue while the unit is disabled |

## Verification
Every visible effect of an issue (`result`, `out_valid`, `fp_disabled_trap` and `invalid_sticky`) is due exactly one rising edge after the edge that samples `in_valid`.

The bench drives each issue on a falling edge and drops the strobe on the next falling edge. It reads the outputs at that same falling edge, which is half a period after the registering edge. One falling edge later it checks that the strobe has returned to zero.

Cases where nothing should change are checked against the result that the previous accepted issue left in the register.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;

    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int DATA_W   = 1 + DP_EXP_W + DP_MAN_W;

    localparam logic [4:0] FUNC_MIN    = 5'h18;
    localparam logic [4:0] FUNC_MAX    = 5'h19;
    localparam logic [4:0] FUNC_MINMAG = 5'h1a;
    localparam logic [4:0] FUNC_MAXMAG = 5'h1b;

    typedef enum logic [1:0] {
        SEL_MIN    = 2'd0,
        SEL_MAX    = 2'd1,
        SEL_MINMAG = 2'd2,
        SEL_MAXMAG = 2'd3
    } sel_op_e;

    typedef struct packed {
        logic    legal;
        sel_op_e op;
    } sel_cmd_t;

    function automatic sel_cmd_t decode_func(input logic [4:0] f);
        sel_cmd_t c;
        c.legal = 1'b1;
        case (f)
            FUNC_MIN:    c.op = SEL_MIN;
            FUNC_MAX:    c.op = SEL_MAX;
            FUNC_MINMAG: c.op = SEL_MINMAG;
            FUNC_MAXMAG: c.op = SEL_MAXMAG;
            default: begin
                c.legal = 1'b0;
                c.op    = SEL_MIN;
            end
        endcase
        return c;
    endfunction

    function automatic logic is_mag_op(input sel_op_e op);
        return (op == SEL_MINMAG) || (op == SEL_MAXMAG);
    endfunction

    function automatic logic is_min_op(input sel_op_e op);
        return (op == SEL_MIN) || (op == SEL_MINMAG);
    endfunction

endpackage

// File: rtl/fpsel_classify.sv
module fpsel_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] val,
    output logic         is_nan,
    output logic         is_snan
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f   = val[W-2 -: EXP_W];
    assign man_f   = val[MAN_W-1:0];
    assign is_nan  = (&exp_f) && (|man_f);
    assign is_snan = is_nan && !man_f[MAN_W-1];
endmodule

// File: rtl/fpsel_cmp.sv
module fpsel_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         any_nan,
    output logic         x_lt_y
);
    logic         sx, sy;
    logic [W-2:0] mx, my;
    logic         both_zero;
    logic         ordered_lt;

    assign sx        = x[W-1];
    assign sy        = y[W-1];
    assign mx        = x[W-2:0];
    assign my        = y[W-2:0];
    assign both_zero = (mx == '0) && (my == '0);

    always_comb begin
        unique case ({sx, sy})
            2'b10:   ordered_lt = 1'b1;
            2'b01:   ordered_lt = 1'b0;
            2'b00:   ordered_lt = (mx < my);
            default: ordered_lt = (mx > my);
        endcase
    end

    assign x_lt_y = !any_nan && !both_zero && ordered_lt;
endmodule

// File: rtl/fpsel_lane.sv
module fpsel_lane
    import fpsel_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int OUT_W = 64,
    localparam int W    = 1 + EXP_W + MAN_W,
    localparam int PAD  = OUT_W - W
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  sel_op_e          op,
    output logic [OUT_W-1:0] res,
    output logic             snan_seen
);
    logic [1:0]   nan_v, snan_v;
    logic [W-1:0] opnd [2];
    logic [W-1:0] ca, cb;
    logic         a_lt_b;
    logic         pick_a;

    assign opnd[0] = a;
    assign opnd[1] = b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fpsel_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val    (opnd[i]),
            .is_nan (nan_v[i]),
            .is_snan(snan_v[i])
        );
    end

    assign ca = is_mag_op(op) ? {1'b0, a[W-2:0]} : a;
    assign cb = is_mag_op(op) ? {1'b0, b[W-2:0]} : b;

    fpsel_cmp #(.W(W)) u_cmp (
        .x      (ca),
        .y      (cb),
        .any_nan(|nan_v),
        .x_lt_y (a_lt_b)
    );

    // B NaN forces A; otherwise min takes A on strict less, max on B <= A
    assign pick_a = nan_v[1] ||
                    (is_min_op(op) ? a_lt_b : (!nan_v[0] && !a_lt_b));

    if (PAD > 0) begin : g_pad
        assign res = {{PAD{1'b0}}, (pick_a ? a : b)};
    end else begin : g_nopad
        assign res = pick_a ? a : b;
    end

    assign snan_seen = |snan_v;
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
    import fpsel_pkg::*;
#(
    parameter int SP_EXP = SP_EXP_W,
    parameter int SP_MAN = SP_MAN_W,
    parameter int DP_EXP = DP_EXP_W,
    parameter int DP_MAN = DP_MAN_W,
    localparam int SP_W  = 1 + SP_EXP + SP_MAN,
    localparam int DP_W  = 1 + DP_EXP + DP_MAN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            fp_en,
    input  logic [4:0]      func,
    input  logic            dbl,
    input  logic [DP_W-1:0] opa,
    input  logic [DP_W-1:0] opb,
    output logic            out_valid,
    output logic [DP_W-1:0] result,
    output logic            invalid_sticky,
    output logic            fp_disabled_trap
);
    sel_cmd_t        cmd;
    logic [DP_W-1:0] lane_res [2];
    logic [1:0]      lane_snan;
    logic            accept;

    assign cmd    = decode_func(func);
    assign accept = in_valid && fp_en && cmd.legal;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int EW = (g == 0) ? SP_EXP : DP_EXP;
        localparam int MW = (g == 0) ? SP_MAN : DP_MAN;
        localparam int LW = 1 + EW + MW;
        fpsel_lane #(.EXP_W(EW), .MAN_W(MW), .OUT_W(DP_W)) u_lane (
            .a        (opa[LW-1:0]),
            .b        (opb[LW-1:0]),
            .op       (cmd.op),
            .res      (lane_res[g]),
            .snan_seen(lane_snan[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid        <= 1'b0;
            fp_disabled_trap <= 1'b0;
            invalid_sticky   <= 1'b0;
            result           <= '0;
        end else begin
            out_valid        <= accept;
            fp_disabled_trap <= in_valid && !fp_en;
            if (accept) begin
                result         <= lane_res[dbl];
                invalid_sticky <= invalid_sticky | lane_snan[dbl];
            end
        end
    end
endmodule

// File: rtl/fp_minmax_chk.sv
module fp_minmax_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        fp_en,
    input logic [4:0]  func,
    input logic        dbl,
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        invalid_sticky,
    input logic        fp_disabled_trap
);
    logic legal_code;
    logic b_nan_dp;

    assign legal_code = (func[4:2] == 3'b110);
    assign b_nan_dp   = (&opb[62:52]) && (|opb[51:0]);

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fp_en && legal_code) |=> out_valid);

    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |=> !out_valid && !fp_disabled_trap);

    p_trap_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fp_en) |=> fp_disabled_trap && !out_valid);

    p_trap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fp_en) |=> $stable(result) && $stable(invalid_sticky));

    p_illegal_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fp_en && !legal_code) |=> !out_valid && !fp_disabled_trap && $stable(result));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        invalid_sticky |=> invalid_sticky);

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fp_en && legal_code && !dbl) |=> (result[63:32] == 32'h0));

    p_nan_b_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fp_en && legal_code && dbl && b_nan_dp) |=> (result == $past(opa)));
endmodule

bind fp_minmax_unit fp_minmax_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .fp_en           (fp_en),
    .func            (func),
    .dbl             (dbl),
    .opa             (opa),
    .opb             (opb),
    .out_valid       (out_valid),
    .result          (result),
    .invalid_sticky  (invalid_sticky),
    .fp_disabled_trap(fp_disabled_trap)
);

// File: tb/tb_fp_minmax_unit.sv
module tb_fp_minmax_unit;
    localparam int CLK_PERIOD = 10;

    localparam logic [63:0] D_P0   = 64'h0000000000000000;
    localparam logic [63:0] D_N0   = 64'h8000000000000000;
    localparam logic [63:0] D_P1   = 64'h3FF0000000000000;
    localparam logic [63:0] D_N1   = 64'hBFF0000000000000;
    localparam logic [63:0] D_P2   = 64'h4000000000000000;
    localparam logic [63:0] D_P3   = 64'h4008000000000000;
    localparam logic [63:0] D_N3   = 64'hC008000000000000;
    localparam logic [63:0] D_QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] S_P1   = 64'h00000000_3F800000;
    localparam logic [63:0] S_P4   = 64'h00000000_40800000;
    localparam logic [63:0] S_N2   = 64'h00000000_C0000000;
    localparam logic [63:0] S_N5   = 64'h00000000_C0A00000;
    localparam logic [63:0] S_QNAN = 64'h00000000_7FC00000;
    localparam logic [63:0] S_SNAN = 64'h00000000_7F800001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        fp_en = 1'b1;
    logic [4:0]  func = 5'h18;
    logic        dbl = 1'b1;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid_sticky;
    logic        fp_disabled_trap;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_minmax_unit dut (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (in_valid),
        .fp_en           (fp_en),
        .func            (func),
        .dbl             (dbl),
        .opa             (opa),
        .opb             (opb),
        .out_valid       (out_valid),
        .result          (result),
        .invalid_sticky  (invalid_sticky),
        .fp_disabled_trap(fp_disabled_trap)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive an issue at a falling edge; outputs are read one falling edge later.
    task automatic issue(input logic [4:0] f, input logic d, input logic en,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        func = f; dbl = d; fp_en = en; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; fp_en = 1'b1;
    endtask

    task automatic run_op(input string tag, input logic [4:0] f, input logic d,
                          input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
        issue(f, d, 1'b1, a, b);
        chk({tag, " out_valid"}, {63'b0, out_valid}, 64'd1);
        chk({tag, " result"}, result, exp);
    endtask

    task automatic t_reset;
        chk("R10 reset out_valid", {63'b0, out_valid}, 64'd0);
        chk("R10 reset trap", {63'b0, fp_disabled_trap}, 64'd0);
        chk("R10 reset sticky", {63'b0, invalid_sticky}, 64'd0);
        chk("R10 reset result", result, 64'd0);
    endtask

    task automatic t_min;
        run_op("R2 min 1,2", 5'h18, 1'b1, D_P1, D_P2, D_P1);
        run_op("R2 min 2,1", 5'h18, 1'b1, D_P2, D_P1, D_P1);
        run_op("R2 min -1,1", 5'h18, 1'b1, D_N1, D_P1, D_N1);
        run_op("R2 min nanA", 5'h18, 1'b1, D_QNAN, D_P2, D_P2);
    endtask

    task automatic t_max;
        run_op("R3 max 1,2", 5'h19, 1'b1, D_P1, D_P2, D_P2);
        run_op("R3 max 2,1", 5'h19, 1'b1, D_P2, D_P1, D_P2);
        run_op("R3 max -3,-1", 5'h19, 1'b1, D_N3, D_N1, D_N1);
        run_op("R3 max nanA", 5'h19, 1'b1, D_QNAN, D_P1, D_P1);
    endtask

    task automatic t_nan_b;
        run_op("R1 min b nan", 5'h18, 1'b1, D_P1, D_QNAN, D_P1);
        run_op("R1 max b nan", 5'h19, 1'b1, D_N3, D_QNAN, D_N3);
        run_op("R1 both nan", 5'h1a, 1'b1, D_QNAN, 64'hFFF8000000000001, D_QNAN);
        chk("R8 quiet nan no flag", {63'b0, invalid_sticky}, 64'd0);
    endtask

    task automatic t_mag;
        run_op("R4 minmag -3,1", 5'h1a, 1'b1, D_N3, D_P1, D_P1);
        run_op("R4 maxmag -3,1", 5'h1b, 1'b1, D_N3, D_P1, D_N3);
        run_op("R4 minmag -1,3", 5'h1a, 1'b1, D_N1, D_P3, D_N1);
        run_op("R4 maxmag -3,3 tie", 5'h1b, 1'b1, D_N3, D_P3, D_N3);
        run_op("R4 minmag -3,3 tie", 5'h1a, 1'b1, D_N3, D_P3, D_P3);
    endtask

    task automatic t_zero;
        run_op("R7 min +0,-0", 5'h18, 1'b1, D_P0, D_N0, D_N0);
        run_op("R7 max +0,-0", 5'h19, 1'b1, D_P0, D_N0, D_P0);
        run_op("R7 max -0,+0", 5'h19, 1'b1, D_N0, D_P0, D_N0);
    endtask

    task automatic t_single;
        run_op("R6 sp min upper ignored", 5'h18, 1'b0,
               64'hDEADBEEF_3F800000, 64'h12345678_40000000, S_P1);
        run_op("R6 sp max -2,-5", 5'h19, 1'b0, 64'hFFFFFFFF_C0000000, S_N5, S_N2);
        run_op("R6 sp b nan", 5'h18, 1'b0, S_P4, S_QNAN, S_P4);
    endtask

    task automatic t_illegal;
        logic [63:0] prev;
        prev = result;
        issue(5'h05, 1'b1, 1'b1, D_P1, D_P2);
        chk("R5 no out_valid", {63'b0, out_valid}, 64'd0);
        chk("R5 no trap", {63'b0, fp_disabled_trap}, 64'd0);
        chk("R5 result held", result, prev);
    endtask

    task automatic t_disabled;
        logic [63:0] prev;
        prev = result;
        issue(5'h18, 1'b0, 1'b0, S_SNAN, S_P1);
        chk("R9 trap raised", {63'b0, fp_disabled_trap}, 64'd1);
        chk("R9 no out_valid", {63'b0, out_valid}, 64'd0);
        chk("R9 result held", result, prev);
        chk("R9 sticky untouched", {63'b0, invalid_sticky}, 64'd0);
        @(negedge clk);
        chk("R9 trap one cycle", {63'b0, fp_disabled_trap}, 64'd0);
    endtask

    task automatic t_sticky;
        run_op("R8 snan in A", 5'h18, 1'b0, S_SNAN, S_P1, S_P1);
        chk("R8 sticky set", {63'b0, invalid_sticky}, 64'd1);
        @(negedge clk);
        chk("R10 out_valid one cycle", {63'b0, out_valid}, 64'd0);
        run_op("R8 later op", 5'h19, 1'b1, D_P1, D_P2, D_P2);
        chk("R8 sticky holds", {63'b0, invalid_sticky}, 64'd1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset clears sticky", {63'b0, invalid_sticky}, 64'd0);
        chk("R10 reset clears result", result, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_min();
        t_max();
        t_nan_b();
        t_mag();
        t_zero();
        t_single();
        t_illegal();
        t_disabled();
        t_sticky();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule